// File: doc/BRIEF.md
# Bias-Cell Voltage-Mode Supervisor

This block is the control and status register pair for the bias cell that serves an SD/MMC pad group. Software writes two enables that power up the bias cell and the pad I/O cells. It also sets a high-impedance mode for the bias output and states which supply level it expects: 3.3 V or 1.8 V. A second register sets input hysteresis and output drive strength for the pads. Each of these settings appears at once on a dedicated output pin.

The block receives a supply-is-high indication from the analog side, which may change at any time. It resynchronizes this indication and compares it with the programmed voltage mode. While the group is powered, an error flag reports either a mismatch that has lasted for 4 µs or the high-impedance mode. The flag can be read in the control register and also drives an interrupt line directly. When the pad I/O enable is low, the pads float and the flag stays clear.

Top module: `bias_vmode_supervisor`

## Requirements
- R1: After reset the control register (byte offset 0x0) reads 0x0020_0000, with only the voltage-mode bit set. The pad register (byte offset 0x4) reads 0x8000_0000, with only hysteresis set. The enable outputs and the interrupt are low, the drive-strength output is 0, and vmode_3v3 and pad_hyst_en are high.
- R2: Control bits are writable and appear on outputs: bit 27 drives bias_pwr_en, bit 26 drives pad_io_en (0 leaves the pads floating), bit 25 drives bias_hiz, and bit 21 drives vmode_3v3 (1 = 3.3 V, 0 = 1.8 V).
- R3: Pad register bit 31 drives pad_hyst_en, and bits 30:29 drive pad_drive.
- R4: Writes to control bits 24 and 23 are ignored, and so are writes to any other unlisted bit. Unlisted bits and unmapped offsets read as zero.
- R5: Control bit 24 shows supply_hi_in after a two-flop synchronizer. A change on the input first reads back after the second rising clock edge.
- R6: Unless bits 27 and 26 are both 1, the error flag (control bit 23) and vmode_irq stay 0, whatever the mode, the supply level and bit 25.
- R7: When the group is powered and bit 25 is 1, the flag is 1 on the first cycle after the write edge, with no qualification delay.
- R8: When the group is powered and not in high-impedance mode, a difference between bit 21 and the synchronized supply level sets the flag once it has lasted QUAL = CLK_HZ·4/10⁶ cycles (400 at 100 MHz). The flag is still 0 one cycle earlier and stays 0 while the two agree.
- R9: If the mismatch goes away before the count completes, the count restarts from zero.
- R10: The flag clears in the same cycle in which its condition disappears.
- R11: vmode_irq always equals the error flag read at bit 23.
- R12: If a power-down write lands on the same edge on which the qualification count completes, the flag never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| supply_hi_in | input | 1 | Asynchronous supply level indication, 1 = 3.3 V |
| bias_pwr_en | output | 1 | Bias cell power-up |
| pad_io_en | output | 1 | Pad I/O power-up, 0 = pads float |
| bias_hiz | output | 1 | Bias output high-impedance |
| vmode_3v3 | output | 1 | Programmed voltage mode, 1 = 3.3 V |
| pad_hyst_en | output | 1 | Pad input hysteresis enable |
| pad_drive | output | 2 | Pad output drive strength |
| vmode_irq | output | 1 | Voltage-mode error interrupt |

## Verification
The qualification counter and a software power-down can act on the same clock edge. In that case the counter reaches its last count on the edge that clears the pad enable. To provoke this, the bench starts a mismatch with a write and then times a power-down write to land exactly QUAL edges later. It then checks that the interrupt and bit 23 stay low in that cycle and the next. A separate check confirms that without the power-down write, the flag rises on that same edge.

// File: rtl/bias_vmode_supervisor.sv
module bias_vmode_supervisor #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int QUAL_US = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              supply_hi_in,
  output logic              bias_pwr_en,
  output logic              pad_io_en,
  output logic              bias_hiz,
  output logic              vmode_3v3,
  output logic              pad_hyst_en,
  output logic [1:0]        pad_drive,
  output logic              vmode_irq
);
  localparam int QUAL_CYC = (CLK_HZ / 1_000_000) * QUAL_US;
  localparam int CNT_W    = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYC - 1);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PAD_OFS  = ADDR_W'(4);
  localparam int B_BIAS = 27, B_IO = 26, B_HIZ = 25, B_SUP = 24, B_ERR = 23, B_VM = 21;
  localparam int B_HYST = 31, B_DRV = 29;

  logic             bias_q, io_q, hiz_q, vm_q, hyst_q;
  logic [1:0]       drv_q;
  logic [1:0]       sup_sync;
  logic [CNT_W-1:0] cnt_q;
  logic             qual_q;
  logic             supply_hi, powered, mismatch, err_flag;
  logic             wr_ctrl, wr_pad;

  assign supply_hi = sup_sync[1];
  assign powered   = bias_q & io_q;
  assign mismatch  = powered & ~hiz_q & (vm_q ^ supply_hi);
  assign err_flag  = (powered & hiz_q) | (qual_q & mismatch);
  assign wr_ctrl   = bus_wr && (bus_addr == CTRL_OFS);
  assign wr_pad    = bus_wr && (bus_addr == PAD_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_q <= 1'b0;
      io_q   <= 1'b0;
      hiz_q  <= 1'b0;
      vm_q   <= 1'b1;
      hyst_q <= 1'b1;
      drv_q  <= 2'd0;
    end else begin
      if (wr_ctrl) begin
        bias_q <= bus_wdata[B_BIAS];
        io_q   <= bus_wdata[B_IO];
        hiz_q  <= bus_wdata[B_HIZ];
        vm_q   <= bus_wdata[B_VM];
      end
      if (wr_pad) begin
        hyst_q <= bus_wdata[B_HYST];
        drv_q  <= bus_wdata[B_DRV+1:B_DRV];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_sync <= 2'b00;
    else        sup_sync <= {sup_sync[0], supply_hi_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      if (!mismatch)              cnt_q <= '0;
      else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
      qual_q <= mismatch && (cnt_q == CNT_LAST);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS) begin
      bus_rdata[B_BIAS] = bias_q;
      bus_rdata[B_IO]   = io_q;
      bus_rdata[B_HIZ]  = hiz_q;
      bus_rdata[B_SUP]  = supply_hi;
      bus_rdata[B_ERR]  = err_flag;
      bus_rdata[B_VM]   = vm_q;
    end else if (bus_addr == PAD_OFS) begin
      bus_rdata[B_HYST]          = hyst_q;
      bus_rdata[B_DRV+1:B_DRV]   = drv_q;
    end
  end

  assign bias_pwr_en = bias_q;
  assign pad_io_en   = io_q;
  assign bias_hiz    = hiz_q;
  assign vmode_3v3   = vm_q;
  assign pad_hyst_en = hyst_q;
  assign pad_drive   = drv_q;
  assign vmode_irq   = err_flag;
endmodule

module bias_vmode_supervisor_chk #(
  parameter int QUAL = 400
) (
  input logic clk,
  input logic rst_n,
  input logic bias_pwr_en,
  input logic pad_io_en,
  input logic bias_hiz,
  input logic vmode_3v3,
  input logic supply_sync,
  input logic vmode_irq
);
  localparam int RW = $clog2(QUAL + 2);
  logic [RW-1:0] mm_run;
  logic          mm_now;

  assign mm_now = bias_pwr_en && pad_io_en && !bias_hiz && (vmode_3v3 != supply_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     mm_run <= '0;
    else if (!mm_now)               mm_run <= '0;
    else if (mm_run != RW'(QUAL))   mm_run <= mm_run + 1'b1;
  end

  // R6
  irq_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vmode_irq |-> (bias_pwr_en && pad_io_en));

  // R7
  hiz_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_pwr_en && pad_io_en && bias_hiz) |-> vmode_irq);

  // R8
  qual_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vmode_irq && !bias_hiz) |-> (mm_run >= RW'(QUAL)));

  // R10
  irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_hiz && !mm_now) |-> !vmode_irq);
endmodule

bind bias_vmode_supervisor bias_vmode_supervisor_chk #(.QUAL(QUAL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bias_pwr_en(bias_pwr_en), .pad_io_en(pad_io_en),
  .bias_hiz(bias_hiz), .vmode_3v3(vmode_3v3), .supply_sync(supply_hi),
  .vmode_irq(vmode_irq)
);

// File: tb/bias_vmode_supervisor_test.sv
`timescale 1ns/1ps
module bias_vmode_supervisor_test;
  localparam int QUAL = 400;
  localparam logic [31:0] BIAS = 32'h0800_0000, IO = 32'h0400_0000, HIZ = 32'h0200_0000, VM = 32'h0020_0000;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, supply_hi_in = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bias_pwr_en, pad_io_en, bias_hiz, vmode_3v3, pad_hyst_en, vmode_irq;
  logic [1:0]  pad_drive;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bias_vmode_supervisor uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .supply_hi_in(supply_hi_in),
    .bias_pwr_en(bias_pwr_en), .pad_io_en(pad_io_en), .bias_hiz(bias_hiz),
    .vmode_3v3(vmode_3v3), .pad_hyst_en(pad_hyst_en), .pad_drive(pad_drive),
    .vmode_irq(vmode_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h0, v); check("R1 ctrl", v, 32'h0020_0000);
    rd(4'h4, v); check("R1 pad", v, 32'h8000_0000);
    check("R1 outs", {bias_pwr_en, pad_io_en, bias_hiz, vmode_3v3, pad_hyst_en, pad_drive, vmode_irq},
          {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0});
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(4'h0, HIZ);
    rd(4'h0, v); check("R2 hiz readback", v, HIZ);
    check("R2 hiz outs", {bias_pwr_en, pad_io_en, bias_hiz, vmode_3v3}, 4'b0010);
    wr(4'h0, BIAS | IO | VM);
    check("R2 power outs", {bias_pwr_en, pad_io_en, bias_hiz, vmode_3v3}, 4'b1101);
    wr(4'h0, 32'h0);
    check("R2 pads float", {pad_io_en, vmode_3v3}, 2'b00);
    wr(4'h4, 32'h4000_0000);
    rd(4'h4, v); check("R3 pad readback", v, 32'h4000_0000);
    check("R3 pad outs", {pad_hyst_en, pad_drive}, 3'b010);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R4 pad unused bits", v, 32'hE000_0000);
    check("R3 pad outs max", {pad_hyst_en, pad_drive}, 3'b111);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(4'h0, 32'hF1DF_FFFF);
    rd(4'h0, v); check("R4 ro bits ignored", v, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v); check("R4 unmapped reads zero", v, 32'h0);
    rd(4'h4, v); check("R4 unmapped write no effect", v, 32'hE000_0000);
    wr(4'h4, 32'h8000_0000);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    supply_hi_in = 1'b1;
    @(negedge clk);
    rd(4'h0, v); check("R5 one edge", v[24], 1'b0);
    @(negedge clk);
    rd(4'h0, v); check("R5 two edges", v[24], 1'b1);
  endtask

  task automatic t_unpowered;
    logic [31:0] v;
    wr(4'h0, BIAS | HIZ);
    check("R6 bias only hiz", vmode_irq, 1'b0);
    wr(4'h0, BIAS);
    idle(QUAL + 5);
    rd(4'h0, v); check("R6 bias only mismatch", {vmode_irq, v[23]}, 2'b00);
    wr(4'h0, IO);
    check("R2 io only pads on", pad_io_en, 1'b1);
    idle(QUAL + 5);
    rd(4'h0, v); check("R6 io only mismatch", {vmode_irq, v[23]}, 2'b00);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_hiz;
    wr(4'h0, BIAS | IO | HIZ | VM);
    check("R7 hiz immediate", {vmode_irq, bias_hiz}, 2'b11);
    wr(4'h0, BIAS | IO | VM);
    check("R10 hiz cleared", vmode_irq, 1'b0);
  endtask

  task automatic t_mismatch;
    logic [31:0] v;
    idle(QUAL + 5);
    check("R8 match stays low", vmode_irq, 1'b0);
    wr(4'h0, BIAS | IO);
    idle(QUAL - 1);
    check("R8 one cycle early", vmode_irq, 1'b0);
    idle(1);
    check("R8 qualified", vmode_irq, 1'b1);
    rd(4'h0, v); check("R11 irq equals bit23", v[23], vmode_irq);
    wr(4'h0, BIAS | IO | VM);
    check("R10 clears with match", vmode_irq, 1'b0);
  endtask

  task automatic t_restart;
    wr(4'h0, BIAS | IO);
    idle(200);
    wr(4'h0, BIAS | IO | VM);
    wr(4'h0, BIAS | IO);
    idle(QUAL - 1);
    check("R9 restarted early", vmode_irq, 1'b0);
    idle(1);
    check("R9 restarted full", vmode_irq, 1'b1);
    wr(4'h0, BIAS | IO | VM);
  endtask

  task automatic t_coincide;
    logic [31:0] v;
    wr(4'h0, BIAS | IO);
    idle(QUAL - 1);
    wr(4'h0, BIAS);
    rd(4'h0, v); check("R12 same edge", {vmode_irq, v[23], pad_io_en}, 3'b000);
    idle(1);
    check("R12 next cycle", vmode_irq, 1'b0);
  endtask

  initial begin
    #(200_000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fields;
    t_readonly;
    t_sync;
    t_unpowered;
    t_hiz;
    t_mismatch;
    t_restart;
    t_coincide;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule